// File: doc/BRIEF.md
# NAND Flash Bus Strobe Sequencer

This block turns single host requests into the pin waveforms of one cycle on an asynchronous NAND flash bus, 8 or 16 bits wide. The host asks for one of four kinds of cycle: a command byte, an address byte, a data write or a data read. The block then steps through a fixed order of programmable phases:

- an optional read turnaround delay;
- setup;
- the strobe, where write enable or read enable is low;
- hold;
- for writes only, a bus-release phase in which the data bus stays driven.

The command latch and address latch enables mark the kind of cycle. Chip enable follows a bank-enable bit.

Two words that software writes set the phase lengths and the mode. A control word holds the mode bits and two 4-bit read turnaround delays. A timing word holds four 8-bit phase counts. Ready/busy from the flash is synchronised on chip. When waiting on busy is enabled, a new cycle is held off while the flash reports busy. Every finished cycle gives a one-clock completion pulse. For reads, the data captured as read enable rises is presented with that pulse.

Top module: `nand_strobe_seq`

## Requirements
- R1: Control bit 2 enables the bank and drives `nand_ce_n` low. Control bit 0 is a soft reset: it forces `nand_ce_n` high, holds the sequencer idle and clears the record of the previous cycle kind. A request is accepted only when bit 2 is set, bit 3 (NAND device select) is set and bit 0 is clear. After reset, `nand_ce_n` is high, `req_ready` and `done` are low, and both strobes are high.
- R2: Request kind encoding is 0 = command, 1 = address, 2 = data write, 3 = data read. `nand_cle` is high during the setup, strobe and hold phases of a command cycle. `nand_ale` is high during those phases of an address cycle. Data cycles raise neither.
- R3: The setup phase lasts setup+1 clocks. Setup is timing bits 7:0. During setup both strobes are high, and a write cycle already drives `nand_dq_out` with `nand_dq_oe` high.
- R4: The strobe phase lasts wait+1 clocks. Wait is timing bits 15:8. `nand_we_n` is low during the strobe of command, address and write cycles. `nand_re_n` is low during the strobe of read cycles. The two are never low together.
- R5: The hold phase lasts hold clocks, where hold is timing bits 23:16. A hold value of 0 gives one clock.
- R6: After hold, a write cycle keeps the bus driven for high-Z clocks, where high-Z is timing bits 31:24. A value of 0 skips this phase. A read cycle never drives the bus.
- R7: A read that directly follows a command cycle is preceded by CLE-to-RE+1 idle clocks, taken from control bits 12:9. A read that directly follows an address cycle is preceded by ALE-to-RE+1 idle clocks, taken from control bits 16:13. No delay is added after a data cycle or after a soft reset.
- R8: `nand_rb_n` (low = busy) passes through two flops. With control bit 1 set, no request is accepted while the synchronised value shows busy, and a release of busy reaches `req_ready` on the second clock edge. With bit 1 clear, busy is ignored.
- R9: `done` is high for exactly one clock, in the clock after the final phase. For a read, `rd_data` then holds the value of `nand_dq_in` captured at the edge where `nand_re_n` rises.
- R10: With control bit 4 clear (8-bit bus), bits 15:8 of `nand_dq_out` and `rd_data` are zero. With bit 4 set, all 16 bits pass through.
- R11: A request is taken at a clock edge where `req_valid` and `req_ready` are both high. The first phase is visible in the next clock, and `req_ready` stays low until the cycle ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ctrl | input | 17 | Control word: mode bits and read turnaround delays |
| cfg_tim | input | 32 | Timing word: setup, wait, hold and high-Z counts |
| req_valid | input | 1 | Host requests a bus cycle |
| req_kind | input | 2 | Cycle kind: 0 = command, 1 = address, 2 = write, 3 = read |
| req_data | input | 16 | Byte or word to send |
| req_ready | output | 1 | Sequencer can accept a request this clock |
| done | output | 1 | One-clock pulse when a cycle finishes |
| rd_data | output | 16 | Data captured by the last read |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 16 | Data bus output value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | 16 | Data bus input value |
| nand_rb_n | input | 1 | Ready/busy from the flash, low = busy |

## Verification
The assertions check on every clock that:

- the two strobes never overlap;
- the latch enables are exclusive;
- a read never drives the bus;
- a strobe implies chip enable;
- every acceptance respects the bank, device and busy gating;
- `done` is a single pulse.

The exact length of each phase, the turnaround delay chosen from the previous cycle kind, byte masking, read capture and the two-edge busy latency are shown only by the bench's scenarios. In those scenarios a behavioural model predicts every pin for every clock.

// File: rtl/nss_pkg.sv
package nss_pkg;

  // Host request kinds; the encoding is visible on req_kind.
  typedef enum logic [1:0] {
    K_CMD  = 2'd0,
    K_ADDR = 2'd1,
    K_WR   = 2'd2,
    K_RD   = 2'd3
  } kind_e;

  // Phases of one bus cycle, in the order they are visited.
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_DLY    = 3'd1,
    PH_SETUP  = 3'd2,
    PH_STROBE = 3'd3,
    PH_HOLD   = 3'd4,
    PH_HIZ    = 3'd5
  } phase_e;

endpackage

// File: rtl/nss_rb_sync.sv
module nss_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= async_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/nss_phase_fsm.sv
module nss_phase_fsm
  import nss_pkg::*;
#(
  parameter int TF = 8,
  parameter int DF = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          start_gate,
  input  logic          wide,
  input  logic          req_valid,
  input  kind_e         req_kind,
  input  logic [DW-1:0] req_data,
  input  logic [TF-1:0] t_setup,
  input  logic [TF-1:0] t_wait,
  input  logic [TF-1:0] t_hold,
  input  logic [TF-1:0] t_hiz,
  input  logic [DF-1:0] d_clr,
  input  logic [DF-1:0] d_ar,
  output phase_e        phase,
  output kind_e         kind,
  output logic [DW-1:0] data,
  output logic          ready,
  output logic          accept,
  output logic          strobe_last,
  output logic          finish
);

  localparam int CW = TF + 1;
  localparam logic [DW-1:0] LOW_MASK = {{(DW-8){1'b0}}, 8'hFF};

  phase_e        ph_q, ph_nx;
  logic [CW-1:0] cnt_q, first_len;
  kind_e         kind_q, hist_k;
  logic          hist_v;
  logic [DW-1:0] data_q;
  logic          is_wr, phase_done;

  // Number of clocks spent in a phase.
  function automatic logic [CW-1:0] len_of(phase_e p, logic [TF-1:0] st,
                                           logic [TF-1:0] wt, logic [TF-1:0] hd,
                                           logic [TF-1:0] hz);
    case (p)
      PH_SETUP:  return CW'(st) + CW'(1);
      PH_STROBE: return CW'(wt) + CW'(1);
      PH_HOLD:   return (hd == '0) ? CW'(1) : CW'(hd);
      PH_HIZ:    return CW'(hz);
      default:   return CW'(1);
    endcase
  endfunction

  // Turnaround before a read, chosen by the previous cycle kind.
  function automatic logic [CW-1:0] turn_len(kind_e k, logic hv, kind_e hk,
                                             logic [DF-1:0] c, logic [DF-1:0] a);
    if (k != K_RD || !hv) return '0;
    if (hk == K_CMD)      return CW'(c) + CW'(1);
    if (hk == K_ADDR)     return CW'(a) + CW'(1);
    return '0;
  endfunction

  function automatic phase_e after(phase_e p, logic wr, logic [TF-1:0] hz);
    case (p)
      PH_DLY:    return PH_SETUP;
      PH_SETUP:  return PH_STROBE;
      PH_STROBE: return PH_HOLD;
      PH_HOLD:   return (wr && hz != '0) ? PH_HIZ : PH_IDLE;
      default:   return PH_IDLE;
    endcase
  endfunction

  always_comb begin
    is_wr      = (kind_q != K_RD);
    ph_nx      = after(ph_q, is_wr, t_hiz);
    ready      = (ph_q == PH_IDLE) && start_gate;
    accept     = ready && req_valid;
    first_len  = turn_len(req_kind, hist_v, hist_k, d_clr, d_ar);
    phase_done = (ph_q != PH_IDLE) && (cnt_q == '0);
    finish     = phase_done && (ph_nx == PH_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      kind_q <= K_CMD;
      data_q <= '0;
      hist_v <= 1'b0;
      hist_k <= K_CMD;
    end else if (soft_rst) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      hist_v <= 1'b0;
    end else if (accept) begin
      kind_q <= req_kind;
      data_q <= wide ? req_data : (req_data & LOW_MASK);
      hist_v <= 1'b1;
      hist_k <= req_kind;
      if (first_len != '0) begin
        ph_q  <= PH_DLY;
        cnt_q <= first_len - CW'(1);
      end else begin
        ph_q  <= PH_SETUP;
        cnt_q <= len_of(PH_SETUP, t_setup, t_wait, t_hold, t_hiz) - CW'(1);
      end
    end else if (phase_done) begin
      ph_q  <= ph_nx;
      cnt_q <= len_of(ph_nx, t_setup, t_wait, t_hold, t_hiz) - CW'(1);
    end else if (ph_q != PH_IDLE) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign phase       = ph_q;
  assign kind        = kind_q;
  assign data        = data_q;
  assign strobe_last = (ph_q == PH_STROBE) && (cnt_q == '0);

  // R5: a finished strobe always hands over to hold
  p_strobe_then_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_STROBE && cnt_q == '0 && !soft_rst) |=> (ph_q == PH_HOLD));

  // R11: an accepted request shows its first phase in the next clock
  p_first_phase_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !soft_rst) |=> (ph_q == PH_SETUP || ph_q == PH_DLY));

  // R6: only write cycles enter the bus-release phase
  p_hiz_writes_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_HIZ) |-> (kind_q != K_RD));

endmodule

// File: rtl/nand_strobe_seq.sv
module nand_strobe_seq
  import nss_pkg::*;
#(
  parameter  int TF      = 8,
  parameter  int DF      = 4,
  parameter  int DW      = 16,
  parameter  int SYNC_N  = 2,
  localparam int CLR_LSB = 9,
  localparam int AR_LSB  = CLR_LSB + DF,
  localparam int CTRL_W  = AR_LSB + DF,
  localparam int TIM_W   = 4 * TF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] cfg_ctrl,
  input  logic [TIM_W-1:0]  cfg_tim,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [DW-1:0]     req_data,
  output logic              req_ready,
  output logic              done,
  output logic [DW-1:0]     rd_data,
  output logic              nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [DW-1:0]     nand_dq_out,
  output logic              nand_dq_oe,
  input  logic [DW-1:0]     nand_dq_in,
  input  logic              nand_rb_n
);

  localparam int B_SRST = 0;
  localparam int B_WAIT = 1;
  localparam int B_BANK = 2;
  localparam int B_NAND = 3;
  localparam int B_WIDE = 4;
  localparam logic [DW-1:0] LOW_MASK = {{(DW-8){1'b0}}, 8'hFF};

  logic soft_rst, wait_en, bank_en, nand_sel, wide;
  logic rb_ready_s, start_gate, start_acc, strobe_last, finish;
  logic drive_ph, ctrl_unused;
  phase_e        phase;
  kind_e         kind;
  logic [DW-1:0] data_q, rd_q;
  logic          done_q;

  assign soft_rst    = cfg_ctrl[B_SRST];
  assign wait_en     = cfg_ctrl[B_WAIT];
  assign bank_en     = cfg_ctrl[B_BANK];
  assign nand_sel    = cfg_ctrl[B_NAND];
  assign wide        = cfg_ctrl[B_WIDE];
  assign ctrl_unused = ^cfg_ctrl[CLR_LSB-1:B_WIDE+1];

  nss_rb_sync #(.STAGES(SYNC_N)) u_rb_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (nand_rb_n),
    .sync_out (rb_ready_s)
  );

  assign start_gate = !soft_rst && bank_en && nand_sel && !(wait_en && !rb_ready_s);

  nss_phase_fsm #(.TF(TF), .DF(DF), .DW(DW)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .start_gate  (start_gate),
    .wide        (wide),
    .req_valid   (req_valid),
    .req_kind    (kind_e'(req_kind)),
    .req_data    (req_data),
    .t_setup     (cfg_tim[TF-1:0]),
    .t_wait      (cfg_tim[2*TF-1:TF]),
    .t_hold      (cfg_tim[3*TF-1:2*TF]),
    .t_hiz       (cfg_tim[4*TF-1:3*TF]),
    .d_clr       (cfg_ctrl[CLR_LSB+DF-1:CLR_LSB]),
    .d_ar        (cfg_ctrl[AR_LSB+DF-1:AR_LSB]),
    .phase       (phase),
    .kind        (kind),
    .data        (data_q),
    .ready       (req_ready),
    .accept      (start_acc),
    .strobe_last (strobe_last),
    .finish      (finish)
  );

  always_comb begin
    drive_ph    = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
    nand_ce_n   = !(bank_en && !soft_rst);
    nand_cle    = drive_ph && (kind == K_CMD);
    nand_ale    = drive_ph && (kind == K_ADDR);
    nand_we_n   = !((phase == PH_STROBE) && (kind != K_RD));
    nand_re_n   = !((phase == PH_STROBE) && (kind == K_RD));
    nand_dq_oe  = (kind != K_RD) && (drive_ph || phase == PH_HIZ);
    nand_dq_out = nand_dq_oe ? data_q : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      rd_q   <= '0;
    end else begin
      done_q <= finish && !soft_rst;
      if (strobe_last && kind == K_RD && !soft_rst)
        rd_q <= wide ? nand_dq_in : (nand_dq_in & LOW_MASK);
    end
  end

  assign done    = done_q;
  assign rd_data = rd_q;

  // R4: write and read strobes never low together
  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  // R2: latch enables are exclusive
  p_latch_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  // R6: a read strobe never coincides with a driven bus
  p_read_no_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_dq_oe);

  // R1: acceptance needs bank, device select and no soft reset
  p_accept_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |-> (cfg_ctrl[B_BANK] && cfg_ctrl[B_NAND] && !cfg_ctrl[B_SRST]));

  // R1: a strobe implies chip enable
  p_strobe_has_ce_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

  // R8: no acceptance while waiting on a busy flash
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |-> !(cfg_ctrl[B_WAIT] && !rb_ready_s));

  // R9: completion is a single-clock pulse
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/nand_strobe_seq_bench.sv
module nand_strobe_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [16:0]   cfg_ctrl = '0;
  logic [31:0]   cfg_tim = '0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_kind = '0;
  logic [DW-1:0] req_data = '0;
  logic [DW-1:0] nand_dq_in = 16'hA5C3;
  logic          nand_rb_n = 1'b1;
  logic          req_ready, done, nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [DW-1:0] rd_data, nand_dq_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_strobe_seq u_nand_strobe_seq (
    .clk(clk), .rst_n(rst_n), .cfg_ctrl(cfg_ctrl), .cfg_tim(cfg_tim),
    .req_valid(req_valid), .req_kind(req_kind), .req_data(req_data),
    .req_ready(req_ready), .done(done), .rd_data(rd_data),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
    .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rb_n(nand_rb_n)
  );

  typedef struct packed {
    logic cle, ale, we_n, re_n, oe;
    logic [DW-1:0] dout;
    logic dn, rchk;
    logic [DW-1:0] rd;
    logic [3:0] tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_fail = 0, cle_cnt = 0, ale_cnt = 0;
  bit   model_on = 1'b0, hist_v = 1'b0, finished = 1'b0;
  logic [1:0] hist_k = '0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd1: return "R1";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      default: return "R9";
    endcase
  endfunction

  function automatic exp_t mk(input bit c, input bit a, input bit wn, input bit rn, input bit oe,
                              input logic [DW-1:0] d, input bit dn, input bit rchk,
                              input logic [DW-1:0] rd, input logic [3:0] tg);
    exp_t e;
    e.cle = c; e.ale = a; e.we_n = wn; e.re_n = rn; e.oe = oe;
    e.dout = d; e.dn = dn; e.rchk = rchk; e.rd = rd; e.tag = tg;
    return e;
  endfunction

  function automatic logic [16:0] mkctrl(input bit srst, input bit wt, input bit bank, input bit nsel,
                                         input bit wide, input logic [3:0] clr, input logic [3:0] ar);
    logic [16:0] c;
    c = '0;
    c[0] = srst; c[1] = wt; c[2] = bank; c[3] = nsel; c[4] = wide;
    c[12:9] = clr; c[16:13] = ar;
    return c;
  endfunction

  // Behavioural model: expected pins for every clock of one cycle.
  task automatic push_op(input logic [1:0] k, input logic [DW-1:0] d);
    int s = int'(cfg_tim[7:0]) + 1;
    int w = int'(cfg_tim[15:8]) + 1;
    int h = (cfg_tim[23:16] == 0) ? 1 : int'(cfg_tim[23:16]);
    int z = int'(cfg_tim[31:24]);
    int dly = 0;
    bit wr = (k != 2'd3);
    logic [DW-1:0] dm = cfg_ctrl[4] ? d : (d & 16'h00FF);
    logic [DW-1:0] rm = cfg_ctrl[4] ? nand_dq_in : (nand_dq_in & 16'h00FF);
    logic [DW-1:0] dv = wr ? dm : '0;
    if (k == 2'd3 && hist_v && hist_k == 2'd0) dly = int'(cfg_ctrl[12:9]) + 1;   // R7 CLE-to-RE
    if (k == 2'd3 && hist_v && hist_k == 2'd1) dly = int'(cfg_ctrl[16:13]) + 1;  // R7 ALE-to-RE
    repeat (dly) q.push_back(mk(0, 0, 1, 1, 0, '0, 0, 0, '0, 4'd7));
    repeat (s) q.push_back(mk(k == 2'd0, k == 2'd1, 1, 1, wr, dv, 0, 0, '0, 4'd3));
    repeat (w) q.push_back(mk(k == 2'd0, k == 2'd1, !wr, wr, wr, dv, 0, 0, '0, 4'd4));
    repeat (h) q.push_back(mk(k == 2'd0, k == 2'd1, 1, 1, wr, dv, 0, 0, '0, 4'd5));
    if (wr) repeat (z) q.push_back(mk(0, 0, 1, 1, 1, dm, 0, 0, '0, 4'd6));
    q.push_back(mk(0, 0, 1, 1, 0, '0, 1, !wr, rm, 4'd9));
    hist_v = 1'b1;
    hist_k = k;
  endtask

  // Cycle-by-cycle comparison, a quarter period after each rising edge.
  initial begin
    exp_t e;
    bit   ok;
    logic ce_exp;
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (model_on) begin
        if (q.size() > 0) e = q.pop_front();
        else e = mk(0, 0, 1, 1, 0, '0, 0, 0, '0, 4'd1);
        ce_exp = !(cfg_ctrl[2] && !cfg_ctrl[0]);
        if (nand_cle) cle_cnt++;
        if (nand_ale) ale_cnt++;
        ok = (nand_cle === e.cle) && (nand_ale === e.ale) && (nand_we_n === e.we_n) &&
             (nand_re_n === e.re_n) && (nand_dq_oe === e.oe) && (nand_dq_out === e.dout) &&
             (done === e.dn) && (nand_ce_n === ce_exp) && (!e.rchk || rd_data === e.rd);
        check(ok, tag_name(e.tag),
              {23'd0, nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe, done, nand_dq_out, rd_data},
              {23'd0, ce_exp, e.cle, e.ale, e.we_n, e.re_n, e.oe, e.dn, e.dout, e.rd});
      end
    end
  end

  task automatic do_op(input logic [1:0] k, input logic [DW-1:0] d, output int waited);
    waited = 0;
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_data = d;
    while (!req_ready && waited < 1000) begin
      @(negedge clk);
      waited++;
    end
    push_op(k, d);
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R11", {63'd0, req_ready}, 64'd0);  // busy with the cycle
    while (q.size() > 0) @(negedge clk);
  endtask

  task automatic expect_blocked(input int n, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'd0; req_data = 16'h00FF;
    repeat (n) begin
      @(negedge clk);
      check(req_ready == 1'b0, req, {63'd0, req_ready}, 64'd0);
    end
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int wt;
    cfg_tim = {8'd2, 8'd0, 8'd2, 8'd1};
    repeat (3) @(negedge clk);
    // R1 reset state
    check(nand_ce_n == 1'b1 && req_ready == 1'b0 && done == 1'b0 && nand_we_n && nand_re_n,
          "R1", {59'd0, nand_ce_n, req_ready, done, nand_we_n, nand_re_n}, {59'd0, 5'b10011});
    rst_n = 1'b1;
    model_on = 1'b1;

    expect_blocked(3, "R1");                          // bank disabled
    cfg_ctrl = mkctrl(0, 0, 1, 0, 0, 4'd2, 4'd3);
    expect_blocked(3, "R1");                          // device select clear
    cfg_ctrl = mkctrl(0, 0, 1, 1, 0, 4'd2, 4'd3);
    @(negedge clk);
    check(nand_ce_n == 1'b0, "R1", {63'd0, nand_ce_n}, 64'd0);

    cle_cnt = 0; ale_cnt = 0;
    do_op(2'd0, 16'h1270, wt);
    check(cle_cnt == 6 && ale_cnt == 0, "R2", 64'(cle_cnt), 64'd6);
    cle_cnt = 0; ale_cnt = 0;
    do_op(2'd1, 16'h0034, wt);
    check(ale_cnt == 6 && cle_cnt == 0, "R2", 64'(ale_cnt), 64'd6);
    do_op(2'd3, 16'h0000, wt);                        // R7 ALE-to-RE delay
    check(rd_data == 16'h00C3, "R10", 64'(rd_data), 64'h00C3);
    do_op(2'd0, 16'h0030, wt);
    do_op(2'd3, 16'h0000, wt);                        // R7 CLE-to-RE delay

    cfg_tim  = {8'd0, 8'd3, 8'd0, 8'd0};
    cfg_ctrl = mkctrl(0, 0, 1, 1, 1, 4'd2, 4'd3);
    do_op(2'd2, 16'hBEEF, wt);                        // R5 long hold, R6 no release phase
    nand_dq_in = 16'h5A69;
    do_op(2'd3, 16'h0000, wt);                        // no delay after a data write
    check(rd_data == 16'h5A69, "R10", 64'(rd_data), 64'h5A69);

    cfg_tim  = {8'd3, 8'd0, 8'd1, 8'd2};
    cfg_ctrl = mkctrl(0, 1, 1, 1, 1, 4'd1, 4'd0);
    nand_rb_n = 1'b0;
    repeat (3) @(negedge clk);
    expect_blocked(4, "R8");
    req_valid = 1'b1;
    nand_rb_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b0, "R8", {63'd0, req_ready}, 64'd0);
    @(negedge clk);
    check(req_ready == 1'b1, "R8", {63'd0, req_ready}, 64'd1);
    req_valid = 1'b0;                                 // dropped before the next edge
    do_op(2'd2, 16'h1234, wt);

    cfg_ctrl = mkctrl(0, 0, 1, 1, 1, 4'd1, 4'd0);
    nand_rb_n = 1'b0;
    repeat (3) @(negedge clk);
    do_op(2'd1, 16'h00A1, wt);
    check(wt == 0, "R8", 64'(wt), 64'd0);             // busy ignored

    do_op(2'd0, 16'h00FF, wt);
    @(negedge clk);
    cfg_ctrl = mkctrl(1, 0, 1, 1, 1, 4'd1, 4'd0);
    hist_v = 1'b0;
    @(negedge clk);
    check(nand_ce_n == 1'b1 && req_ready == 1'b0, "R1", {62'd0, nand_ce_n, req_ready}, 64'd2);
    @(negedge clk);
    cfg_ctrl = mkctrl(0, 0, 1, 1, 1, 4'd1, 4'd0);
    nand_dq_in = 16'hC0DE;
    do_op(2'd3, 16'h0000, wt);                        // R7 history cleared
    check(rd_data == 16'hC0DE, "R9", 64'(rd_data), 64'hC0DE);

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule